// File: doc/BRIEF.md
# BCD Time Record Reader

This block is the register front end of a real-time clock. It holds two byte registers: a command/status register and a data register. A separate counter supplies the current time of day as seven packed BCD bytes on input ports. The block does no timekeeping of its own.

When software writes the get-time command to the command register, the block restarts a read index. Each later read of the data register returns the next time field, starting with the year and ending with the seconds. After the seconds field the index returns to the year, so a program can read the whole record with seven back-to-back data reads. With any other command in the command register, a data read returns the stored data byte with the acknowledge bit set. A read of the status register always shows the acknowledge bit set.

Reads use a one-cycle strobe. In the default variant the read data is combinational and is valid in the cycle of the strobe. Each strobe that reads a time field moves the index forward by exactly one.

Top module: `bcd_time_reader`

## Requirements
- R1: After reset the command, data and index registers are zero. A status read then returns 0x80, and a data read returns 0x80.
- R2: A status read (`rd_en`=1, `rd_sel`=0) returns the last byte written to the command register (`wr_sel`=0) with bit 7 forced to 1.
- R3: A command write of 0x15 sets the read index to zero. This also holds when a data read occurs in the same cycle: that read returns the field at the old index, and the next data read returns the year.
- R4: While the command register holds 0x15, successive data reads (`rd_sel`=1) return, in this order: year, month, day of month, weekday, hour, minute, second.
- R5: Each time field is passed through unchanged as packed BCD, with the tens digit in bits [7:4] and the units digit in bits [3:0]. The value returned is the one present on the time input at the time of the read.
- R6: The data read that follows the seconds field returns the year again.
- R7: While the command register holds any value other than 0x15, a data read returns the last byte written to the data register (`wr_sel`=1) with bit 7 forced to 1.
- R8: Status reads, data-register writes and idle cycles leave the read index unchanged.
- R9: Each cycle with a data read strobe in get-time mode advances the index by exactly one, including strobes in consecutive cycles.
- R10: In any cycle without a read strobe, `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wr_sel | input | 1 | Write target: 0 command register, 1 data register |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rd_sel | input | 1 | Read source: 0 status register, 1 data register |
| rd_data | output | 8 | Read byte, valid in the strobe cycle; zero when idle |
| tm_year | input | 8 | BCD year, two digits |
| tm_month | input | 8 | BCD month |
| tm_mday | input | 8 | BCD day of month |
| tm_wday | input | 8 | BCD weekday |
| tm_hour | input | 8 | BCD hour |
| tm_minute | input | 8 | BCD minute |
| tm_second | input | 8 | BCD second |

## Verification
The assertions check these on every cycle: the index stays inside the seven-field range, a get-time write clears the index, a time-field read steps the index by one with wrap, every other cycle holds the index, a status read carries the acknowledge bit, and the output is zero when idle. Some behaviours can be shown only by the bench scenarios, which compare against a behavioural model on every clock. These are the order of the fields across a whole record, the wrap back to the year, a read and a restart landing in the same cycle, the mode switch between field streaming and stored-data readback, and live time values changing between reads.

// File: rtl/bcdrd_pkg.sv
package bcdrd_pkg;

   localparam int unsigned FIELD_COUNT = 7;

   typedef enum logic [2:0] {
      FLD_YEAR   = 3'd0,
      FLD_MONTH  = 3'd1,
      FLD_MDAY   = 3'd2,
      FLD_WDAY   = 3'd3,
      FLD_HOUR   = 3'd4,
      FLD_MINUTE = 3'd5,
      FLD_SECOND = 3'd6
   } field_e;

endpackage

// File: rtl/bcdrd_regs.sv
module bcdrd_regs #(
   parameter int unsigned DATA_W  = 8,
   parameter logic [7:0]  GET_CMD = 8'h15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] cmd_q,
   output logic [DATA_W-1:0] data_q,
   output logic              get_time,
   output logic              restart
);

   localparam logic [DATA_W-1:0] CMD_MATCH = DATA_W'(GET_CMD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         data_q <= '0;
      end else if (wr_en) begin
         if (wr_sel) data_q <= wr_data;
         else        cmd_q  <= wr_data;
      end
   end

   assign get_time = (cmd_q == CMD_MATCH);
   assign restart  = wr_en && !wr_sel && (wr_data == CMD_MATCH);

endmodule

// File: rtl/bcdrd_index.sv
module bcdrd_index #(
   parameter int unsigned COUNT = 7,
   localparam int unsigned IW   = (COUNT > 1) ? $clog2(COUNT) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          advance,
   input  logic          restart,
   output logic [IW-1:0] idx
);

   localparam logic [IW-1:0] LAST = IW'(COUNT - 1);

   generate
      if (COUNT < 2) begin : g_bad_count
         $error("bcdrd_index: COUNT must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)        idx <= '0;
      else if (restart)  idx <= '0;
      else if (advance)  idx <= (idx == LAST) ? '0 : idx + 1'b1;
   end

   assert_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= LAST);

   assert_idx_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (idx == '0));

   assert_idx_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !restart) |=>
         (idx == (($past(idx) == LAST) ? '0 : $past(idx) + 1'b1)));

   assert_idx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!advance && !restart) |=> $stable(idx));

endmodule

// File: rtl/bcdrd_field_mux.sv
module bcdrd_field_mux #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned COUNT  = 7,
   localparam int unsigned IW    = (COUNT > 1) ? $clog2(COUNT) : 1
) (
   input  logic [COUNT*DATA_W-1:0] fields_flat,
   input  logic [IW-1:0]           idx,
   output logic [DATA_W-1:0]       field
);

   logic [DATA_W-1:0] slot [COUNT];

   generate
      for (genvar g = 0; g < COUNT; g++) begin : g_slot
         assign slot[g] = fields_flat[g*DATA_W +: DATA_W];
      end
   endgenerate

   always_comb begin
      field = '0;
      for (int i = 0; i < COUNT; i++) begin
         if (idx == IW'(i)) field = slot[i];
      end
   end

endmodule

// File: rtl/bcd_time_reader.sv
module bcd_time_reader
   import bcdrd_pkg::*;
#(
   parameter int unsigned DATA_W       = 8,
   parameter logic [7:0]  GET_CMD      = 8'h15,
   parameter int unsigned READ_LATENCY = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic              rd_sel,
   output logic [DATA_W-1:0] rd_data,
   input  logic [DATA_W-1:0] tm_year,
   input  logic [DATA_W-1:0] tm_month,
   input  logic [DATA_W-1:0] tm_mday,
   input  logic [DATA_W-1:0] tm_wday,
   input  logic [DATA_W-1:0] tm_hour,
   input  logic [DATA_W-1:0] tm_minute,
   input  logic [DATA_W-1:0] tm_second
);

   localparam int unsigned       IW       = $clog2(FIELD_COUNT);
   localparam logic [DATA_W-1:0] ACK_MASK = DATA_W'(1) << (DATA_W - 1);

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("bcd_time_reader: DATA_W must hold a BCD byte");
      end
      if (READ_LATENCY > 1) begin : g_bad_latency
         $error("bcd_time_reader: READ_LATENCY must be 0 or 1");
      end
   endgenerate

   logic [DATA_W-1:0]             cmd_q, data_q, field;
   logic                          get_time, restart, advance;
   logic [IW-1:0]                 idx;
   logic [FIELD_COUNT*DATA_W-1:0] fields_flat;
   logic [DATA_W-1:0]             rd_next;

   assign fields_flat = {tm_second, tm_minute, tm_hour, tm_wday,
                         tm_mday, tm_month, tm_year};

   bcdrd_regs #(.DATA_W(DATA_W), .GET_CMD(GET_CMD)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .cmd_q    (cmd_q),
      .data_q   (data_q),
      .get_time (get_time),
      .restart  (restart)
   );

   assign advance = rd_en && rd_sel && get_time;

   bcdrd_index #(.COUNT(FIELD_COUNT)) u_index (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (advance),
      .restart (restart),
      .idx     (idx)
   );

   bcdrd_field_mux #(.DATA_W(DATA_W), .COUNT(FIELD_COUNT)) u_mux (
      .fields_flat (fields_flat),
      .idx         (idx),
      .field       (field)
   );

   always_comb begin
      rd_next = '0;
      if (rd_en) begin
         if (!rd_sel)       rd_next = cmd_q | ACK_MASK;
         else if (get_time) rd_next = field;
         else               rd_next = data_q | ACK_MASK;
      end
   end

   generate
      if (READ_LATENCY == 0) begin : g_comb_out
         assign rd_data = rd_next;

         assert_status_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && !rd_sel) |-> rd_data[DATA_W-1]);

         assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_en |-> (rd_data == '0));
      end else begin : g_reg_out
         always_ff @(posedge clk) begin
            if (!rst_n) rd_data <= '0;
            else        rd_data <= rd_next;
         end

         assert_status_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && !rd_sel) |=> rd_data[DATA_W-1]);
      end
   endgenerate

endmodule

// File: tb/bcd_time_reader_test.sv
module bcd_time_reader_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, wr_sel = 1'b0, rd_en = 1'b0, rd_sel = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic [7:0] tv [7];

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;

   int m_cmd = 0, m_data = 0, m_idx = 0;

   always #2 clk = ~clk;

   bcd_time_reader uut (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
      .tm_year(tv[0]), .tm_month(tv[1]), .tm_mday(tv[2]), .tm_wday(tv[3]),
      .tm_hour(tv[4]), .tm_minute(tv[5]), .tm_second(tv[6])
   );

   function automatic int expect_read();
      if (!rd_en)       return 0;
      if (!rd_sel)      return m_cmd | 8'h80;
      if (m_cmd == 'h15) return int'(tv[m_idx]);
      return m_data | 8'h80;
   endfunction

   task automatic step(input string tag, input bit we, input bit ws,
                       input int wd, input bit re, input bit rs);
      int exp_v;
      wr_en = we; wr_sel = ws; wr_data = wd[7:0];
      rd_en = re; rd_sel = rs;
      #1;
      exp_v = expect_read();
      vectors++;
      if (int'(rd_data) != exp_v) begin
         miscompares++;
         $display("FAIL %s: rd_data=%02h expected=%02h", tag, rd_data, exp_v[7:0]);
      end
      @(posedge clk);
      if (re && rs && m_cmd == 'h15 && !(we && !ws && wd == 'h15))
         m_idx = (m_idx + 1) % 7;
      if (we && !ws) begin
         m_cmd = wd;
         if (wd == 'h15) m_idx = 0;
      end
      if (we && ws) m_data = wd;
      @(negedge clk);
   endtask

   task automatic set_time(input int y, mo, d, w, h, mi, s);
      tv[0] = y[7:0]; tv[1] = mo[7:0]; tv[2] = d[7:0]; tv[3] = w[7:0];
      tv[4] = h[7:0]; tv[5] = mi[7:0]; tv[6] = s[7:0];
   endtask

   initial begin
      #100000;
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog: run hung");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      set_time('h24, 'h07, 'h31, 'h03, 'h23, 'h59, 'h58);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 / R10: reset state
      step("R10", 0, 0, 0, 0, 0);
      step("R1", 0, 0, 0, 1, 0);
      step("R1", 0, 0, 0, 1, 1);
      // R2: status echoes command with ack bit
      step("R2", 1, 0, 'h23, 0, 0);
      step("R2", 0, 0, 0, 1, 0);
      step("R2", 1, 0, 'h95, 1, 0);
      step("R2", 0, 0, 0, 1, 0);
      // R7: stored data with ack bit
      step("R7", 1, 1, 'h41, 0, 0);
      step("R7", 0, 0, 0, 1, 1);
      step("R7", 1, 1, 'h05, 1, 1);
      step("R7", 0, 0, 0, 1, 1);
      // R4 / R5: full record in order, back-to-back strobes (R9)
      step("R3", 1, 0, 'h15, 0, 0);
      for (int i = 0; i < 7; i++) step("R4", 0, 0, 0, 1, 1);
      // R6: wrap to year
      step("R6", 0, 0, 0, 1, 1);
      step("R9", 0, 0, 0, 1, 1);
      // R8: status read, data write, idle leave index alone
      step("R8", 0, 0, 0, 1, 0);
      step("R8", 1, 1, 'h66, 0, 0);
      step("R8", 0, 0, 0, 0, 0);
      step("R8", 0, 0, 0, 1, 1);
      // R3: restart via command
      step("R3", 1, 0, 'h15, 0, 0);
      step("R3", 0, 0, 0, 1, 1);
      step("R3", 0, 0, 0, 1, 1);
      // R3: restart in same cycle as a data read
      step("R3", 1, 0, 'h15, 1, 1);
      step("R3", 0, 0, 0, 1, 1);
      // R5: live values with other digits
      set_time('h99, 'h12, 'h01, 'h06, 'h00, 'h07, 'h45);
      for (int i = 0; i < 8; i++) step("R5", 0, 0, 0, 1, 1);
      // R7: leave get-time mode
      step("R7", 1, 0, 'h16, 0, 0);
      step("R7", 0, 0, 0, 1, 1);
      step("R2", 0, 0, 0, 1, 0);
      step("R10", 0, 0, 0, 0, 1);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule